// File: doc/BRIEF.md
# Fracturable Multi-Mode Logic Element

This block is one logic element of a programmable fabric. It holds a single look-up table of 2^K entries (K = 4 by default) and two D flip-flops. A static mode code sets how the two parts work together. In the first mode the table is one K-input function that feeds flip-flop 0. In the second mode the table is split into two (K-1)-input functions. Both halves share the low inputs, and each half feeds its own flip-flop. In the third mode the two flip-flops form a 2-bit shift register that is fed from a dedicated serial input.

Each output has its own configuration bit. This bit picks either the flip-flop value or the table value that feeds it. A test-enable input takes control of both flip-flops and turns them into a scan path. The path runs from the scan input through flip-flop 0, then through flip-flop 1, to the scan output. This lets the stored state be shifted out and read.

The configuration word, the mode code and the output-select bits are static inputs that a configuration loader outside this block drives. The element has no streaming data path and no handshake. All of its pins are plain control and data wires.

Top module: `le_fracturable`

## Requirements
- R1: A high `rst` at a rising clock edge clears both flip-flops to 0. The reset is synchronous and active high.
- R2: When `mode` is 2'b00 or 2'b11 (single-function mode), combinational output 0 equals `lut_cfg[lut_in]`, using all K inputs as the table index.
- R3: When `mode` is 2'b01 (split mode), combinational output 0 equals `lut_cfg[lut_in[K-2:0]]`, which is an entry of the lower half of the table. The top input `lut_in[K-1]` has no effect on either output.
- R4: In every mode, combinational output 1 equals `lut_cfg[2^(K-1) + lut_in[K-2:0]]`, which is an entry of the upper half of the table.
- R5: In single-function mode with `test_en` low, flip-flop 0 loads combinational output 0 and flip-flop 1 keeps its value.
- R6: In split mode with `test_en` low, flip-flop 0 loads the lower-half value and flip-flop 1 loads the upper-half value.
- R7: When `mode` is 2'b10 (shift mode) with `test_en` low, flip-flop 0 loads `sr_in` and flip-flop 1 loads the old value of flip-flop 0.
- R8: When `test_en` is high, in any mode, flip-flop 0 loads `scan_in` and flip-flop 1 loads the old value of flip-flop 0. `scan_out` always shows flip-flop 1.
- R9: `le_out[i]` shows flip-flop i when `out_reg_sel[i]` is 1, and shows combinational output i when `out_reg_sel[i]` is 0.
- R10: Reset takes priority over `test_en` and over every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lut_in | input | K | Table address inputs |
| lut_cfg | input | 2^K | Table contents, one bit per entry |
| mode | input | 2 | 00/11 single function, 01 split, 10 shift register |
| out_reg_sel | input | 2 | Per-output select: 1 registered, 0 combinational |
| sr_in | input | 1 | Serial data input used in shift mode |
| test_en | input | 1 | Scan enable; overrides the mode for both flip-flops |
| scan_in | input | 1 | Scan chain input, loaded into flip-flop 0 |
| scan_out | output | 1 | Scan chain output, the value of flip-flop 1 |
| le_out | output | 2 | Element outputs 0 and 1 |

## Verification
The bench builds the element with its default K = 4, so the table has 16 entries. Each address in both halves is small enough that random inputs reach it many times. Random configuration words, mode codes, output selects and scan controls are mixed, so every mode is seen both entering and leaving scan operation. Directed steps cover these cases: reset while scan is active, the top input toggling in split mode, and a fixed serial pattern in shift mode.

// File: rtl/le_pkg.sv
package le_pkg;
  typedef enum logic [1:0] {
    LE_MODE_SINGLE = 2'b00,
    LE_MODE_SPLIT  = 2'b01,
    LE_MODE_SHIFT  = 2'b10,
    LE_MODE_ALT    = 2'b11
  } le_mode_e;
endpackage

// File: rtl/le_lut_frac.sv
module le_lut_frac #(
  parameter int K = 4
) (
  input  logic [K-1:0]      lut_in,
  input  logic [(1<<K)-1:0] lut_cfg,
  input  le_pkg::le_mode_e  mode,
  output logic [1:0]        comb
);
  localparam int HALF = 1 << (K - 1);

  logic [HALF-1:0] tab_lo;
  logic [HALF-1:0] tab_hi;
  logic            val_lo;
  logic            val_hi;
  logic            val_full;

  assign tab_lo = lut_cfg[HALF-1:0];
  assign tab_hi = lut_cfg[2*HALF-1:HALF];

  // The two halves share the low inputs; the top input picks a half to form the full table.
  assign val_lo   = tab_lo[lut_in[K-2:0]];
  assign val_hi   = tab_hi[lut_in[K-2:0]];
  assign val_full = lut_in[K-1] ? val_hi : val_lo;

  always_comb begin
    comb[1] = val_hi;
    comb[0] = (mode == le_pkg::LE_MODE_SPLIT) ? val_lo : val_full;
  end
endmodule

// File: rtl/le_ff_pair.sv
module le_ff_pair (
  input  logic             clk,
  input  logic             rst,
  input  logic             test_en,
  input  logic             scan_in,
  input  logic             sr_in,
  input  le_pkg::le_mode_e mode,
  input  logic [1:0]       comb,
  output logic [1:0]       q
);
  logic [1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (test_en) begin
      q_nxt = {q[0], scan_in};
    end else begin
      case (mode)
        le_pkg::LE_MODE_SPLIT: q_nxt = comb;
        le_pkg::LE_MODE_SHIFT: q_nxt = {q[0], sr_in};
        default:               q_nxt = {q[1], comb[0]};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 2'b00;
    else     q <= q_nxt;
  end

  p_scan_path_r8: assert property (@(posedge clk) disable iff (rst)
    test_en |=> (q[0] == $past(scan_in)) && (q[1] == $past(q[0])));

  p_shift_mode_r7: assert property (@(posedge clk) disable iff (rst)
    (!test_en && mode == le_pkg::LE_MODE_SHIFT) |=> (q[0] == $past(sr_in)) && (q[1] == $past(q[0])));

  p_split_capture_r6: assert property (@(posedge clk) disable iff (rst)
    (!test_en && mode == le_pkg::LE_MODE_SPLIT) |=> (q == $past(comb)));

  p_single_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!test_en && (mode == le_pkg::LE_MODE_SINGLE || mode == le_pkg::LE_MODE_ALT))
      |=> (q[1] == $past(q[1])) && (q[0] == $past(comb[0])));
endmodule

// File: rtl/le_out_sel.sv
module le_out_sel #(
  parameter int N_OUT = 2
) (
  input  logic [N_OUT-1:0] reg_val,
  input  logic [N_OUT-1:0] comb_val,
  input  logic [N_OUT-1:0] sel,
  output logic [N_OUT-1:0] out
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    assign out[i] = sel[i] ? reg_val[i] : comb_val[i];
  end
endmodule

// File: rtl/le_fracturable.sv
module le_fracturable #(
  parameter int K = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [K-1:0]      lut_in,
  input  logic [(1<<K)-1:0] lut_cfg,
  input  logic [1:0]        mode,
  input  logic [1:0]        out_reg_sel,
  input  logic              sr_in,
  input  logic              test_en,
  input  logic              scan_in,
  output logic              scan_out,
  output logic [1:0]        le_out
);
  le_pkg::le_mode_e mode_e;
  logic [1:0]       comb;
  logic [1:0]       ffq;

  assign mode_e = le_pkg::le_mode_e'(mode);

  le_lut_frac #(.K(K)) u_lut (
    .lut_in  (lut_in),
    .lut_cfg (lut_cfg),
    .mode    (mode_e),
    .comb    (comb)
  );

  le_ff_pair u_ffs (
    .clk     (clk),
    .rst     (rst),
    .test_en (test_en),
    .scan_in (scan_in),
    .sr_in   (sr_in),
    .mode    (mode_e),
    .comb    (comb),
    .q       (ffq)
  );

  le_out_sel #(.N_OUT(2)) u_osel (
    .reg_val  (ffq),
    .comb_val (comb),
    .sel      (out_reg_sel),
    .out      (le_out)
  );

  assign scan_out = ffq[1];

  p_reset_priority_r10: assert property (@(posedge clk)
    (rst && test_en) |=> (scan_out == 1'b0));
endmodule

// File: tb/le_fracturable_tb.sv
module le_fracturable_tb;
  localparam int K = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  lut_in = '0;
  logic [15:0] lut_cfg = '0;
  logic [1:0]  mode = '0;
  logic [1:0]  out_reg_sel = '0;
  logic        sr_in = 1'b0;
  logic        test_en = 1'b0;
  logic        scan_in = 1'b0;
  logic        scan_out;
  logic [1:0]  le_out;

  int n_chk = 0;
  int n_fail = 0;
  logic [1:0] mff = 2'b00;
  logic [1:0] saved;

  always #4 clk = ~clk;

  le_fracturable #(.K(K)) u_dut (
    .clk(clk), .rst(rst), .lut_in(lut_in), .lut_cfg(lut_cfg), .mode(mode),
    .out_reg_sel(out_reg_sel), .sr_in(sr_in), .test_en(test_en),
    .scan_in(scan_in), .scan_out(scan_out), .le_out(le_out)
  );

  function automatic logic [1:0] f_comb(input logic [15:0] c, input logic [3:0] x, input logic [1:0] m);
    logic [1:0] r;
    r[1] = c[8 + int'(x[2:0])];
    r[0] = (m == 2'b01) ? c[int'(x[2:0])] : c[int'(x)];
    return r;
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check outputs, then advance the model at the edge.
  task automatic cyc(input logic r, input logic [3:0] x, input logic [15:0] c,
                     input logic [1:0] m, input logic [1:0] s, input logic sr,
                     input logic te, input logic si, input string tag);
    logic [1:0] cb;
    logic [1:0] ex;
    rst = r; lut_in = x; lut_cfg = c; mode = m; out_reg_sel = s;
    sr_in = sr; test_en = te; scan_in = si;
    #1;
    cb = f_comb(c, x, m);
    for (int i = 0; i < 2; i++) ex[i] = s[i] ? mff[i] : cb[i];
    check({tag, " R9 le_out"}, le_out, ex);
    check("R8 scan_out", {1'b0, scan_out}, {1'b0, mff[1]});
    @(posedge clk);
    if (r)             mff = 2'b00;
    else if (te)       mff = {mff[0], si};
    else if (m == 2'b01) mff = cb;
    else if (m == 2'b10) mff = {mff[0], sr};
    else               mff = {mff[1], cb[0]};
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20251));
    @(negedge clk);
    // R1 and R10: reset wins over an active scan
    cyc(1, 4'h0, 16'hFFFF, 2'b10, 2'b11, 1, 1, 1, "R10");
    cyc(1, 4'h0, 16'hFFFF, 2'b10, 2'b11, 1, 1, 1, "R10");
    check("R1 reset state", le_out, 2'b00);
    // R3: top input has no effect in split mode
    cyc(0, 4'b0101, 16'hA5C3, 2'b01, 2'b00, 0, 0, 0, "R3");
    saved = le_out;
    cyc(0, 4'b1101, 16'hA5C3, 2'b01, 2'b00, 0, 0, 0, "R3");
    check("R3 top input ignored", le_out, saved);
    // R2 and R4: full-table and upper-half values
    cyc(0, 4'b1011, 16'h0800, 2'b00, 2'b00, 0, 0, 0, "R2 R4");
    check("R2 full index 11", le_out, 2'b11);
    // R7: serial pattern in shift mode
    cyc(0, 4'h0, 16'h0000, 2'b10, 2'b11, 1, 0, 0, "R7");
    cyc(0, 4'h0, 16'h0000, 2'b10, 2'b11, 0, 0, 0, "R7");
    check("R7 shift pattern", le_out, 2'b10);
    cyc(0, 4'h0, 16'h0000, 2'b10, 2'b11, 1, 0, 0, "R7");
    check("R7 shift pattern", le_out, 2'b01);
    // R5 and R6 plus everything else under random stimulus
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] m;
      logic te;
      string tg;
      m  = 2'($urandom);
      te = ($urandom % 6) == 0;
      tg = te ? "R8" : (m == 2'b01) ? "R3 R6" : (m == 2'b10) ? "R7" : "R2 R5";
      cyc(($urandom % 60) == 0, 4'($urandom), 16'($urandom), m, 2'($urandom),
          1'($urandom), te, 1'($urandom), tg);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule